// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. The line rests high. A frame starts with one low start bit. The data bits follow, least significant first, then an optional parity bit, then one or two high stop bits. A single 32-bit setup word sets every frame property: the clocks per bit, the character length, the stop-bit count, the parity mode and optional clear-to-send flow control. All bit timing comes from the system clock.

The host holds `tx_valid` with a byte on `tx_data` while `tx_busy` is low. The byte is taken on the next clock edge. At that same edge the block copies the setup word, so later changes to the word affect only later characters. Data bits above the selected character length are dropped.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, and whenever no frame is being sent, `txd` is 1 and `tx_busy` is 0.
- R2: A frame is a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then the stop bits at 1. Each bit lasts exactly N clocks, where N is `setup_word[23:0]`; a value of 0 acts as 1.
- R3: `setup_word[29:28]` holds 8 minus the character length, so codes 0, 1, 2 and 3 send 8, 7, 6 and 5 data bits.
- R4: `setup_word[27]` = 1 sends two stop bits; 0 sends one.
- R5: `setup_word[26]` = 1 adds a parity bit. With `setup_word[25]` = 0 the parity is even (bit 24 = 0) or odd (bit 24 = 1) over the sent data bits. With `setup_word[25]` = 1 the bit is fixed at the value of bit 24 (1 for mark, 0 for space).
- R6: A byte is accepted at a rising edge where `tx_valid` is 1 and `tx_busy` is 0 (subject to R9). From that edge `tx_busy` is 1 and the start bit is on the line. `tx_busy` falls at the edge that ends the last stop bit.
- R7: A `tx_valid` seen while `tx_busy` is 1 is ignored: no extra frame is sent afterwards.
- R8: The setup word is captured at acceptance. Changing it during a frame does not alter that frame, and the next frame uses the value present at its own acceptance.
- R9: With `setup_word[30]` = 1, no byte is accepted while `cts` is 0. With `setup_word[30]` = 0, `cts` has no effect.
- R10: `tx_data` bits at and above the selected character length affect neither the data bits nor the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_word | input | 32 | Frame setup: clocks per bit, length, stops, parity, flow control |
| tx_valid | input | 1 | Host offers a byte |
| tx_data | input | 8 | Byte to send |
| cts | input | 1 | Clear to send; used only when flow control is enabled |
| tx_busy | output | 1 | A frame is in progress |
| txd | output | 1 | Serial output line |

## Verification
Two events can fall on the same clock edge: a frame ends and the next byte is accepted, and that acceptance coincides with a new setup word. The bench drives a new setup word, byte and `tx_valid` in the very cycle that `tx_busy` goes low. Before that, it corrupts the setup word in the first cycle of each frame and keeps offering another byte for a few cycles while busy. Each frame is compared bit by bit and clock by clock with a frame built arithmetically from the intended setup. Any leak of the corrupt word, the rejected byte or a late capture shows up as a wrong bit, a wrong bit length or an extra frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DIV_W  = 24;
    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int LEN_W  = IDX_W + 1;

    localparam int SW_LEN_HI   = 29;
    localparam int SW_LEN_LO   = 28;
    localparam int SW_TWO_STOP = 27;
    localparam int SW_PAR_EN   = 26;
    localparam int SW_PAR_FIX  = 25;
    localparam int SW_PAR_ODD  = 24;
    localparam int SW_FLOW     = 30;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_phase_e;

    typedef struct packed {
        logic [DIV_W-1:0] period_m1;
        logic [LEN_W-1:0] nbits;
        logic             two_stop;
        logic             par_en;
    } frame_cfg_t;

    typedef struct packed {
        tx_phase_e         phase;
        logic [IDX_W-1:0]  bit_idx;
        logic              stop_idx;
        logic [DATA_W-1:0] shreg;
        logic              par_bit;
        frame_cfg_t        cfg;
        logic              busy;
        logic              txd;
    } tx_regs_t;

    function automatic frame_cfg_t decode_setup(input logic [31:0] sw);
        frame_cfg_t c;
        c.period_m1 = (sw[DIV_W-1:0] == '0) ? '0 : sw[DIV_W-1:0] - 1'b1;
        c.nbits     = LEN_W'(DATA_W) - {{(LEN_W-2){1'b0}}, sw[SW_LEN_HI:SW_LEN_LO]};
        c.two_stop  = sw[SW_TWO_STOP];
        c.par_en    = sw[SW_PAR_EN];
        return c;
    endfunction

endpackage

// File: rtl/tx_baud_timer.sv
module tx_baud_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] period_m1,
    output logic         bit_end
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || cnt_q == '0) begin
            cnt_d = period_m1;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign bit_end = (cnt_q == '0);

    // the count can only leave its reload value by stepping down
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(restart) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  nbits,
    input  logic              fixed,
    input  logic              odd_or_mark,
    output logic              par_bit
);
    logic [DATA_W-1:0] kept;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign kept[i] = data[i] & (LEN_W'(i) < nbits);
    end

    always_comb begin
        if (fixed) par_bit = odd_or_mark;
        else       par_bit = (^kept) ^ odd_or_mark;
    end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] setup_word,
    input  logic        tx_valid,
    input  logic [7:0]  tx_data,
    input  logic        cts,
    output logic        tx_busy,
    output logic        txd
);
    tx_regs_t   q, d;
    frame_cfg_t new_cfg;
    logic       accept;
    logic       bit_end;
    logic       new_par;
    logic [DIV_W-1:0] period_sel;

    assign new_cfg    = decode_setup(setup_word);
    assign accept     = (q.phase == TX_IDLE) && tx_valid && (!setup_word[SW_FLOW] || cts);
    assign period_sel = accept ? new_cfg.period_m1 : q.cfg.period_m1;

    tx_baud_timer #(.W(DIV_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (accept),
        .period_m1 (period_sel),
        .bit_end   (bit_end)
    );

    tx_parity_gen #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_parity (
        .data        (tx_data),
        .nbits       (new_cfg.nbits),
        .fixed       (setup_word[SW_PAR_FIX]),
        .odd_or_mark (setup_word[SW_PAR_ODD]),
        .par_bit     (new_par)
    );

    always_comb begin
        d = q;
        if (accept) begin
            d.phase    = TX_START;
            d.cfg      = new_cfg;
            d.shreg    = tx_data;
            d.par_bit  = new_par;
            d.bit_idx  = '0;
            d.stop_idx = 1'b0;
            d.busy     = 1'b1;
            d.txd      = 1'b0;
        end else if (q.phase != TX_IDLE && bit_end) begin
            case (q.phase)
                TX_START: begin
                    d.phase = TX_DATA;
                    d.txd   = q.shreg[0];
                    d.shreg = q.shreg >> 1;
                end
                TX_DATA: begin
                    if ({1'b0, q.bit_idx} == q.cfg.nbits - 1'b1) begin
                        if (q.cfg.par_en) begin
                            d.phase = TX_PARITY;
                            d.txd   = q.par_bit;
                        end else begin
                            d.phase = TX_STOP;
                            d.txd   = 1'b1;
                        end
                    end else begin
                        d.bit_idx = q.bit_idx + 1'b1;
                        d.txd     = q.shreg[0];
                        d.shreg   = q.shreg >> 1;
                    end
                end
                TX_PARITY: begin
                    d.phase = TX_STOP;
                    d.txd   = 1'b1;
                end
                TX_STOP: begin
                    if (q.stop_idx == q.cfg.two_stop) begin
                        d.phase = TX_IDLE;
                        d.busy  = 1'b0;
                        d.txd   = 1'b1;
                    end else begin
                        d.stop_idx = 1'b1;
                    end
                end
                default: begin
                    d.phase = TX_IDLE;
                    d.busy  = 1'b0;
                    d.txd   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.phase    <= TX_IDLE;
            q.txd      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_busy = q.busy;
    assign txd     = q.txd;

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    assert_start_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);

    assert_index_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == TX_DATA) |-> ({1'b0, q.bit_idx} < q.cfg.nbits));

    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy)) |-> $stable(q.cfg));

    assert_flow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && setup_word[SW_FLOW] && !cts) |=> !tx_busy);

    assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == TX_STOP) |-> txd);

endmodule

// File: tb/test_uart_tx_framer.sv
module test_uart_tx_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] setup_word = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        cts = 1'b0;
    logic        tx_busy;
    logic        txd;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    uart_tx_framer i_uart_tx_framer (
        .clk(clk), .rst_n(rst_n), .setup_word(setup_word), .tx_valid(tx_valid),
        .tx_data(tx_data), .cts(cts), .tx_busy(tx_busy), .txd(txd)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] make_setup(input int div, input int code,
                                               input int stop2, input int mode, input int flow);
        logic [2:0] pb;
        case (mode)
            1: pb = 3'b100;
            2: pb = 3'b101;
            3: pb = 3'b110;
            4: pb = 3'b111;
            default: pb = 3'b000;
        endcase
        return (32'(flow) << 30) | (32'(code) << 28) | (32'(stop2) << 27)
             | (32'(pb) << 24) | 32'(div);
    endfunction

    // Offers a byte at a negedge and checks the whole frame clock by clock.
    task automatic run_frame(input logic [31:0] sw, input logic [7:0] data, input string req);
        int div, nb, nbits_total, idx;
        logic [15:0] bits;
        logic par;
        div = (sw[23:0] == 0) ? 1 : int'(sw[23:0]);
        nb  = 8 - int'(sw[29:28]);
        par = 1'b0;
        for (int i = 0; i < nb; i++) par ^= data[i];
        if (sw[25]) par = sw[24];
        else        par = par ^ sw[24];
        idx = 0;
        bits[idx++] = 1'b0;
        for (int i = 0; i < nb; i++) bits[idx++] = data[i];
        if (sw[26]) bits[idx++] = par;
        bits[idx++] = 1'b1;
        if (sw[27]) bits[idx++] = 1'b1;
        nbits_total = idx;

        setup_word = sw;
        tx_data    = data;
        tx_valid   = 1'b1;
        @(negedge clk);
        setup_word = sw ^ 32'h3F00_0005;   // R8: corrupt word mid-frame
        tx_data    = ~data;                // R7: offered while busy
        begin
            int cyc = 0;
            for (int b = 0; b < nbits_total; b++) begin
                int bad = 0;
                int got = 0;
                for (int c = 0; c < div; c++) begin
                    if (cyc == 3) tx_valid = 1'b0;
                    if (txd !== bits[b] || tx_busy !== 1'b1) begin
                        bad = 1;
                        got = {30'd0, tx_busy, txd};
                    end
                    cyc++;
                    @(negedge clk);
                end
                check(bad ? {req, " bit"} : req, bad ? got : 2 + int'(bits[b]), 2 + int'(bits[b]));
            end
        end
        check("R6 busy falls after last stop", int'(tx_busy), 0);
        check("R1 line high when idle", int'(txd), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset busy", int'(tx_busy), 0);
        check("R1 reset line", int'(txd), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(txd), 1);

        // R2 R3 R4 R5 R8 R10 sweep; frames run back to back (R6 coincidence)
        for (int div = 0; div < 4; div++)
            for (int code = 0; code < 4; code++)
                for (int stop2 = 0; stop2 < 2; stop2++)
                    for (int mode = 0; mode < 5; mode++)
                        for (int j = 0; j < 2; j++) begin
                            logic [7:0] dat;
                            dat = 8'((div * 37 + code * 11 + mode * 5 + stop2 * 3 + j * 101) | 8'hE0 * j);
                            cts = 1'b1;
                            run_frame(make_setup(div, code, stop2, mode, j), dat,
                                      "R2 R3 R4 R5 R10 frame");
                        end

        // R7: rejected byte must not follow
        begin
            int extra = 0;
            repeat (12) begin
                if (tx_busy !== 1'b0 || txd !== 1'b1) extra = 1;
                @(negedge clk);
            end
            check("R7 no frame from byte offered while busy", extra, 0);
        end

        // R9: flow control holds off
        begin
            int moved = 0;
            setup_word = make_setup(2, 0, 0, 1, 1);
            tx_data    = 8'h5A;
            cts        = 1'b0;
            tx_valid   = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (tx_busy !== 1'b0 || txd !== 1'b1) moved = 1;
            end
            check("R9 held while cts low", moved, 0);
            cts = 1'b1;
            run_frame(make_setup(2, 0, 0, 1, 1), 8'h5A, "R9 released by cts");
        end
        cts = 1'b0;
        run_frame(make_setup(3, 1, 1, 2, 0), 8'hC3, "R9 cts ignored when disabled");

        // R2 with a larger divisor, R10 high bits ignored in 5-bit mode
        cts = 1'b1;
        run_frame(make_setup(7, 3, 1, 1, 0), 8'hF6, "R2 R10 long bits");

        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule